// File: doc/BRIEF.md
# Truncating Approximate Multiply-Accumulate Unit

This block forms a dot product of two unsigned operand streams at reduced cost. Each operand arrives with a truncation depth. The unit forces that many low-order bits of both operands to zero and multiplies the reduced values. It then adds the product to a running sum. Dropping the low bits shrinks the significant part of the multiplier's inputs, so the product is cheaper to form. The price is a result that can only fall below the exact one.

A set of terms is framed by two markers. A start marker opens the set and a last marker closes it. One cycle after the closing term, a single-cycle valid pulse presents the final sum and the number of terms in the set. The truncation depth is a runtime input sampled with every term, so one set may mix depths. A depth of zero turns the unit into an exact multiply-accumulate.

Top module: `trunc_mac`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_sum` and `res_terms` are 0.
- R2: For an accepted term with depth b = `trunc_bits`, bits [b-1:0] of both `op_a` and `op_b` are forced to zero before the multiply. Any b of `OP_W` or more gives a product of zero.
- R3: With `trunc_bits` = 0, the reported sum equals the exact sum of `op_a`*`op_b` over the set.
- R4: The sum is the sum of the truncated products of all accepted terms in the set. It is `2*OP_W + clog2(MAX_TERMS)` bits wide and does not wrap for up to `MAX_TERMS` terms of maximum operands.
- R5: A cycle with `in_valid` low is ignored. `op_a`, `op_b`, `trunc_bits`, `in_start` and `in_last` have no effect in that cycle, the running sum is unchanged, and no result is produced.
- R6: An accepted term with `in_start` high discards any partial sum, so the set begins with that term's product and a count of 1.
- R7: An accepted term with `in_last` high makes `res_valid` high for exactly the next cycle. In that cycle `res_sum` holds the set's sum and `res_terms` holds its count. The next accepted term begins a new set from zero.
- R8: The reported sum never exceeds the exact sum of the untruncated products.
- R9: `res_sum` and `res_terms` keep their values between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Term qualifier |
| in_start | input | 1 | Term opens a new set |
| in_last | input | 1 | Term closes the current set |
| op_a | input | OP_W | First unsigned operand |
| op_b | input | OP_W | Second unsigned operand |
| trunc_bits | input | TRUNC_W | Number of low bits to clear on both operands |
| res_valid | output | 1 | One-cycle result pulse |
| res_sum | output | ACC_W | Sum of the closed set |
| res_terms | output | CNT_W | Number of terms in the closed set |

## Verification
The assertions assume that no set contains more than `MAX_TERMS` accepted terms. The count bound and the no-wrap width both rest on this assumption. They also assume that the marker inputs are meaningful only while `in_valid` is high. The stimulus keeps every set at `MAX_TERMS` terms or fewer, including the full-scale set of sixteen maximum products. Outside valid cycles it drives random operands and raised markers, so the assertions can show that these cycles change nothing.

// File: rtl/trunc_mac_pkg.sv
package trunc_mac_pkg;
    localparam int unsigned DEF_OP_W      = 8;
    localparam int unsigned DEF_MAX_TERMS = 16;

    function automatic int unsigned acc_width(input int unsigned op_w, input int unsigned max_terms);
        return 2 * op_w + $clog2(max_terms);
    endfunction
endpackage

// File: rtl/trunc_mask.sv
module trunc_mask #(
    parameter int unsigned OP_W    = 8,
    parameter int unsigned TRUNC_W = 4
) (
    input  logic [OP_W-1:0]    val_raw,
    input  logic [TRUNC_W-1:0] depth,
    output logic [OP_W-1:0]    val_cut
);
    always_comb begin
        for (int i = 0; i < OP_W; i++) begin
            val_cut[i] = (i >= int'(depth)) ? val_raw[i] : 1'b0;
        end
    end
endmodule

// File: rtl/trunc_mul.sv
module trunc_mul #(
    parameter int unsigned OP_W = 8
) (
    input  logic [OP_W-1:0]   mul_a,
    input  logic [OP_W-1:0]   mul_b,
    output logic [2*OP_W-1:0] mul_p
);
    always_comb begin
        mul_p = (2*OP_W)'(mul_a) * (2*OP_W)'(mul_b);
    end
endmodule

// File: rtl/trunc_accum.sv
module trunc_accum #(
    parameter int unsigned OP_W      = 8,
    parameter int unsigned MAX_TERMS = 16,
    parameter int unsigned ACC_W     = 20,
    parameter int unsigned CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_last,
    input  logic [2*OP_W-1:0] prod,
    output logic              res_valid,
    output logic [ACC_W-1:0]  res_sum,
    output logic [CNT_W-1:0]  res_terms
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic             fresh;
        logic             rv;
        logic [ACC_W-1:0] rsum;
        logic [CNT_W-1:0] rcnt;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] acc_base;
    logic [CNT_W-1:0] cnt_base;

    always_comb begin
        st_d     = st_q;
        st_d.rv  = 1'b0;
        acc_base = (in_start || st_q.fresh) ? '0 : st_q.acc;
        cnt_base = (in_start || st_q.fresh) ? '0 : st_q.cnt;
        if (in_valid) begin
            st_d.acc   = acc_base + ACC_W'(prod);
            st_d.cnt   = cnt_base + CNT_W'(1);
            st_d.fresh = in_last;
            if (in_last) begin
                st_d.rv   = 1'b1;
                st_d.rsum = st_d.acc;
                st_d.rcnt = st_d.cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.rv;
    assign res_sum   = st_q.rsum;
    assign res_terms = st_q.rcnt;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.acc) && !st_q.rv);

    // R7
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rv |-> $past(in_valid && in_last));

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> $stable(st_q.rsum) && $stable(st_q.rcnt));

    // R4
    term_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_TERMS));
endmodule

// File: rtl/trunc_mac.sv
module trunc_mac
    import trunc_mac_pkg::*;
#(
    parameter int unsigned OP_W      = DEF_OP_W,
    parameter int unsigned MAX_TERMS = DEF_MAX_TERMS,
    parameter int unsigned TRUNC_W   = $clog2(OP_W + 1),
    parameter int unsigned ACC_W     = acc_width(OP_W, MAX_TERMS),
    parameter int unsigned CNT_W     = $clog2(MAX_TERMS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_start,
    input  logic               in_last,
    input  logic [OP_W-1:0]    op_a,
    input  logic [OP_W-1:0]    op_b,
    input  logic [TRUNC_W-1:0] trunc_bits,
    output logic               res_valid,
    output logic [ACC_W-1:0]   res_sum,
    output logic [CNT_W-1:0]   res_terms
);
    localparam int unsigned N_OPS = 2;

    logic [OP_W-1:0]   ops_raw [N_OPS];
    logic [OP_W-1:0]   ops_cut [N_OPS];
    logic [2*OP_W-1:0] prod;

    assign ops_raw[0] = op_a;
    assign ops_raw[1] = op_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_mask
        trunc_mask #(.OP_W(OP_W), .TRUNC_W(TRUNC_W)) mask_i (
            .val_raw (ops_raw[g]),
            .depth   (trunc_bits),
            .val_cut (ops_cut[g])
        );
    end

    trunc_mul #(.OP_W(OP_W)) mul_i (
        .mul_a (ops_cut[0]),
        .mul_b (ops_cut[1]),
        .mul_p (prod)
    );

    trunc_accum #(
        .OP_W(OP_W), .MAX_TERMS(MAX_TERMS), .ACC_W(ACC_W), .CNT_W(CNT_W)
    ) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_last   (in_last),
        .prod      (prod),
        .res_valid (res_valid),
        .res_sum   (res_sum),
        .res_terms (res_terms)
    );

    // R8
    never_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> prod <= (2*OP_W)'(op_a) * (2*OP_W)'(op_b));

    // R3
    bypass_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && trunc_bits == '0) |-> prod == (2*OP_W)'(op_a) * (2*OP_W)'(op_b));

    // R2
    full_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(trunc_bits) >= OP_W) |-> prod == '0);
endmodule

// File: tb/trunc_mac_tb_top.sv
module trunc_mac_tb_top;
    localparam int OP_W = 8;
    localparam int MAXT = 16;
    localparam int TW   = 4;
    localparam int AW   = 20;
    localparam int CW   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
    logic [OP_W-1:0] op_a = '0, op_b = '0;
    logic [TW-1:0] trunc_bits = '0;
    logic res_valid;
    logic [AW-1:0] res_sum;
    logic [CW-1:0] res_terms;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    longint exp_sum_q[$];
    longint exp_cnt_q[$];
    longint exact_q[$];
    longint mdl_acc = 0, mdl_cnt = 0, mdl_exact = 0;
    bit     mdl_fresh = 1;
    longint last_sum = 0, last_cnt = 0;

    always #10 clk = ~clk;

    trunc_mac dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .op_a(op_a), .op_b(op_b), .trunc_bits(trunc_bits),
        .res_valid(res_valid), .res_sum(res_sum), .res_terms(res_terms)
    );

    function automatic longint cut(input longint v, input int b);
        if (b >= OP_W) return 0;
        return v & ~((longint'(1) << b) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one term, model updated and expectation queued on last.
    task automatic term(input int a, input int b, input int tb, input bit st, input bit ls);
        @(posedge clk); #1;
        in_valid = 1; op_a = a[OP_W-1:0]; op_b = b[OP_W-1:0];
        trunc_bits = tb[TW-1:0]; in_start = st; in_last = ls;
        if (st || mdl_fresh) begin mdl_acc = 0; mdl_cnt = 0; mdl_exact = 0; end
        mdl_acc   += cut(a, tb) * cut(b, tb);
        mdl_exact += longint'(a) * longint'(b);
        mdl_cnt++;
        mdl_fresh = ls;
        if (ls) begin
            exp_sum_q.push_back(mdl_acc);
            exp_cnt_q.push_back(mdl_cnt);
            exact_q.push_back(mdl_exact);
        end
    endtask

    // R5: idle cycle with garbage on every other input
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 0; op_a = OP_W'($urandom); op_b = OP_W'($urandom);
            trunc_bits = TW'($urandom); in_start = 1; in_last = 1;
        end
    endtask

    // Monitor: pops expectations as results appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                if (exp_sum_q.size() == 0) begin
                    chk(0, "R5/R7 unexpected result", res_sum, -1);
                end else begin
                    longint es, ec, ex;
                    es = exp_sum_q.pop_front();
                    ec = exp_cnt_q.pop_front();
                    ex = exact_q.pop_front();
                    chk(res_sum == AW'(es), "R2/R4/R6 sum", res_sum, es);
                    chk(res_terms == CW'(ec), "R7 term count", res_terms, ec);
                    chk(longint'(res_sum) <= ex, "R8 not above exact", res_sum, ex);
                    last_sum = res_sum; last_cnt = res_terms;
                end
            end else begin
                if (res_sum != AW'(last_sum) || res_terms != CW'(last_cnt))
                    chk(0, "R9 hold", res_sum, last_sum);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk(res_valid == 0, "R1 valid", res_valid, 0);
        chk(res_sum == 0, "R1 sum", res_sum, 0);
        chk(res_terms == 0, "R1 terms", res_terms, 0);
        @(negedge clk); rst_n = 1;

        // R3: exact mode
        term(200, 3, 0, 1, 0); term(17, 255, 0, 0, 0);
        term(1, 1, 0, 0, 0); term(99, 77, 0, 0, 1);
        begin
            longint ex;
            ex = 200*3 + 17*255 + 1 + 99*77;
            chk(exp_sum_q[0] == ex, "R3 model exact", exp_sum_q[0], ex);
        end
        idle(2);
        // R2/R5: depth 3 with gaps
        term(255, 255, 3, 1, 0); idle(3); term(7, 200, 3, 0, 0);
        idle(1); term(129, 15, 3, 0, 0); term(64, 9, 3, 0, 1);
        idle(2);
        // R2: full truncation, and depth above width
        term(255, 255, 8, 1, 0); term(200, 100, 12, 0, 0); term(128, 128, 15, 0, 1);
        idle(1);
        // R4: full-scale set of MAXT terms, no wrap
        for (int i = 0; i < MAXT; i++) term(255, 255, 0, i == 0, i == MAXT-1);
        idle(1);
        // R6: partial set discarded by a start mid-stream
        term(10, 10, 0, 1, 0); term(20, 20, 0, 0, 0); term(30, 30, 0, 0, 0);
        term(5, 6, 1, 1, 0); term(33, 44, 2, 0, 0); term(250, 3, 4, 0, 1);
        // R7: single-term set back to back, then set without start marker
        term(12, 13, 0, 1, 1);
        term(40, 41, 1, 0, 0); term(100, 200, 5, 0, 1);
        term(77, 66, 2, 0, 1);
        idle(4);
        // random sets
        for (int s = 0; s < 20; s++) begin
            int n;
            n = 1 + ($urandom % MAXT);
            for (int i = 0; i < n; i++) begin
                term($urandom % 256, $urandom % 256, $urandom % 10, i == 0, i == n-1);
                if ($urandom % 4 == 0) idle(1);
            end
        end
        idle(4);
        chk(exp_sum_q.size() == 0, "R7 all results seen", exp_sum_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule